// File: doc/BRIEF.md
# SPI NAND Page Operation Sequencer

This block sits between a flash management layer and a serial frame engine that shifts single SPI NAND commands. A caller asks for one high-level operation (page read, page program, block erase, device reset or on-die ECC switch) and supplies a row address, a column offset, a byte count and a poll timeout. The sequencer breaks the request into the ordered list of device commands. It hands those commands to the frame engine one at a time, and it keeps polling the device status register until the device is no longer busy. It then classifies the result into a three-bit completion code.

Page data never passes through the sequencer. For cache loads and cache reads it only tells the frame engine the direction and the length, and the engine streams the bytes between the host and the device. The only bytes the sequencer itself exchanges are single register bytes: the status byte and the configuration byte. These travel on `fr_rdata` and `fr_wbyte` and are marked with `fr_local`.

States and transitions of the controller:
- IDLE: a valid `start` goes to PAGE_LD (read), WREN (program, erase), RST_CMD (reset) or CFG_RD (ECC switch).
- WREN goes to CACHE_LD for a program and to ERASE for an erase.
- CACHE_LD goes to EXEC. EXEC, ERASE and PAGE_LD each go to POLL.
- POLL repeats while the device reports busy. It goes to DONE on timeout. When the device is ready it goes to CACHE_RD (a read with a usable ECC result) or to DONE.
- CACHE_RD goes to DONE.
- RST_CMD goes to RST_WAIT, and RST_WAIT goes to POLL when the wait counter expires.
- CFG_RD goes to DONE if the ECC bit already has the wanted value, otherwise to CFG_WR. CFG_WR goes to DONE.
- DONE goes back to IDLE.

Top module: `snand_seq`

## Requirements
- R1: In IDLE, a `start` with `op` 0 (read), 1 (program), 2 (erase), 3 (reset) or 4 (ECC switch) is accepted, and `busy` is high from the next cycle. A `start` with `op` 5 to 7, or any `start` while `busy` is high, is ignored: no frame is issued and the running operation is unchanged.
- R2: Each frame is presented on `fr_req` with its fields held stable until the cycle in which `fr_done` is high. `fr_addr` is right-aligned and the engine sends its low `fr_naddr` bytes most significant first. `fr_dir` is 0 for no data, 1 for transmit and 2 for receive. Frames with no address or data show zero in the unused fields.
- R3: A read issues 0x13 with the three-byte row, then polls. On a usable ECC result it issues 0x03 with the three address bytes {000, row[6], col[11:8]}, col[7:0], 0xFF, receiving `len` bytes from the stream.
- R4: A program issues 0x06 with no address. It then issues 0x84 with the two bytes {000, row[6], col[11:8]}, col[7:0], transmitting `len` bytes from the stream. It then issues 0x10 with the three-byte row and polls.
- R5: An erase issues 0x06, then 0xD8 with the three-byte row, then polls.
- R6: A status poll is opcode 0x0F with one address byte `STAT_REG` (default 0xC0), receiving one local byte. Status bit 0 set means busy, and the poll frame is repeated.
- R7: After a read, status bits [5:4] decide the result: 00 gives code 0 and 01 gives code 1, both followed by the cache read. 10 or 11 gives code 2, and no cache read is issued.
- R8: After a program, status bit 3 set gives code 3. After an erase, status bit 2 set gives code 4. Otherwise the code is 0. Fail bits that do not belong to the operation are ignored, and a read ignores both fail bits.
- R9: The poll cycle counter starts at zero when POLL is entered. A busy reply that arrives when the counter is at or above `tmo_limit` ends the operation with code 5.
- R10: A reset issues 0xFF with no address. It then lets at least `RST_WAIT` cycles pass with no frame, then polls until ready, and ends with code 0.
- R11: An ECC switch reads the configuration register (0x0F, one address byte `CFG_REG`, default 0xB0). If bit 4 already equals `ecc_on`, it ends with no write. Otherwise it writes (0x1F, same address, one local transmit byte) the read value with only bit 4 replaced. The code is 0 in both cases.
- R12: `done` is a one-cycle pulse carrying a valid `code`, and `busy` is low in the cycle after it. `fr_req` is never high while `busy` is low. After reset, `busy`, `done` and `fr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Operation request |
| op | input | 3 | Operation type (0 read, 1 program, 2 erase, 3 reset, 4 ECC switch) |
| row | input | ROW_W | Page or block row address |
| col | input | COL_W | Column offset inside the page |
| len | input | LEN_W | Byte count for the cache transfer |
| ecc_on | input | 1 | Wanted on-die ECC state for op 4 |
| tmo_limit | input | TMO_W | Poll timeout in cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| code | output | 3 | Completion code: 0 ok, 1 ECC corrected, 2 ECC uncorrectable, 3 program fail, 4 erase fail, 5 timeout |
| fr_req | output | 1 | Frame request to the engine |
| fr_opcode | output | 8 | Command byte |
| fr_naddr | output | 2 | Number of address bytes |
| fr_addr | output | 24 | Right-aligned address bytes |
| fr_dir | output | 2 | Data phase: 0 none, 1 transmit, 2 receive |
| fr_local | output | 1 | Data byte is exchanged with the sequencer, not the stream |
| fr_len | output | LEN_W | Data phase length in bytes |
| fr_wbyte | output | 8 | Local transmit byte |
| fr_done | input | 1 | Frame finished (one cycle) |
| fr_rdata | input | 8 | Last byte received in a local receive frame |

## Verification
The sweeps cover read, program and erase over rows with row bit 6 both clear and set. They use columns whose high nibble varies and zero to two busy replies before the device is ready. This separates errors in plane-bit placement, byte order and poll repetition. Reads are run with every value of the ECC field while the unrelated fail bits are set, which tells a correct classification and cache-read skip apart from one that is led by the wrong bit. Programs and erases each see both fail bits, so a swapped flag shows up.

Timeout runs use a device that never becomes ready, a zero limit and a limit that is never reached, which pins down the comparison boundary. Reset runs measure the quiet gap after 0xFF. A chain of ECC switches shows both the skipped and the performed write. Invalid opcodes and a start during a running read confirm that requests are ignored.

// File: rtl/snand_pkg.sv
package snand_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_RESET  = 3'd3,
        OP_ECCCFG = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        RC_OK         = 3'd0,
        RC_ECC_FIX    = 3'd1,
        RC_ECC_BAD    = 3'd2,
        RC_PROG_FAIL  = 3'd3,
        RC_ERASE_FAIL = 3'd4,
        RC_TIMEOUT    = 3'd5
    } rc_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_CACHE_LD,
        ST_EXEC,
        ST_ERASE,
        ST_PAGE_LD,
        ST_POLL,
        ST_CACHE_RD,
        ST_RST_CMD,
        ST_RST_WAIT,
        ST_CFG_RD,
        ST_CFG_WR,
        ST_DONE
    } seq_st_e;

    localparam logic [7:0] OPC_WREN      = 8'h06;
    localparam logic [7:0] OPC_PAGE_LOAD = 8'h13;
    localparam logic [7:0] OPC_CACHE_RD  = 8'h03;
    localparam logic [7:0] OPC_CACHE_LD  = 8'h84;
    localparam logic [7:0] OPC_EXEC      = 8'h10;
    localparam logic [7:0] OPC_BLK_ERASE = 8'hD8;
    localparam logic [7:0] OPC_GET_REG   = 8'h0F;
    localparam logic [7:0] OPC_SET_REG   = 8'h1F;
    localparam logic [7:0] OPC_RESET     = 8'hFF;

    localparam logic [1:0] DIR_NONE = 2'd0;
    localparam logic [1:0] DIR_TX   = 2'd1;
    localparam logic [1:0] DIR_RX   = 2'd2;

    localparam int SB_BUSY   = 0;
    localparam int SB_EFAIL  = 2;
    localparam int SB_PFAIL  = 3;
    localparam int SB_ECC_LO = 4;
    localparam int CFG_ECC_BIT = 4;

endpackage

// File: rtl/snand_addr_pack.sv
module snand_addr_pack #(
    parameter int ROW_W = 17,
    parameter int COL_W = 12
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [23:0]      row_addr,
    output logic [23:0]      cache_rd_addr,
    output logic [23:0]      cache_ld_addr
);
    logic [23:0] row_x;
    logic [15:0] col_x;
    logic [7:0]  hi_byte;

    always_comb begin
        row_x   = 24'(row);
        col_x   = 16'(col);
        // plane select: row bit 6 lands in bit 4 of the leading column byte
        hi_byte = col_x[15:8] | {3'b000, row_x[6], 4'b0000};
        row_addr      = row_x;
        cache_rd_addr = {hi_byte, col_x[7:0], 8'hFF};
        cache_ld_addr = {8'h00, hi_byte, col_x[7:0]};
    end
endmodule

// File: rtl/snand_cycle_timer.sv
module snand_cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt >= limit);

    AST_TMR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt >= $past(cnt))); // R9
endmodule

// File: rtl/snand_stat_eval.sv
module snand_stat_eval
    import snand_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] stat,
    output logic       dev_busy,
    output rc_e        rc,
    output logic       read_go
);
    always_comb begin
        dev_busy = stat[SB_BUSY];
        rc       = RC_OK;
        read_go  = 1'b0;
        unique case (op)
            OP_READ: begin
                unique case (stat[SB_ECC_LO +: 2])
                    2'b00:   read_go = 1'b1;
                    2'b01: begin
                        rc      = RC_ECC_FIX;
                        read_go = 1'b1;
                    end
                    default: rc = RC_ECC_BAD;
                endcase
            end
            OP_PROG:  if (stat[SB_PFAIL]) rc = RC_PROG_FAIL;
            OP_ERASE: if (stat[SB_EFAIL]) rc = RC_ERASE_FAIL;
            default:  rc = RC_OK;
        endcase
    end
endmodule

// File: rtl/snand_seq.sv
module snand_seq
    import snand_pkg::*;
#(
    parameter int          ROW_W    = 17,
    parameter int          COL_W    = 12,
    parameter int          LEN_W    = 12,
    parameter int          TMO_W    = 20,
    parameter int          RST_WAIT = 125000,
    parameter logic [7:0]  STAT_REG = 8'hC0,
    parameter logic [7:0]  CFG_REG  = 8'hB0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [LEN_W-1:0] len,
    input  logic             ecc_on,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic [2:0]       code,
    output logic             fr_req,
    output logic [7:0]       fr_opcode,
    output logic [1:0]       fr_naddr,
    output logic [23:0]      fr_addr,
    output logic [1:0]       fr_dir,
    output logic             fr_local,
    output logic [LEN_W-1:0] fr_len,
    output logic [7:0]       fr_wbyte,
    input  logic             fr_done,
    input  logic [7:0]       fr_rdata
);
    localparam int RW_W = $clog2(RST_WAIT + 1);
    localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);
    localparam logic [7:0] ECC_MASK = 8'(1) << CFG_ECC_BIT;

    seq_st_e          st_q, st_d;
    op_e              op_q;
    rc_e              rc_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q;
    logic [TMO_W-1:0] tmo_q;
    logic             want_q;
    logic [7:0]       cfg_q;
    logic [7:0]       cfg_new;

    logic             op_valid, accept;
    logic             tmo_exp, wait_exp;
    logic             dev_busy, read_go;
    rc_e              eval_rc;
    logic [23:0]      row_addr, cache_rd_addr, cache_ld_addr;

    assign op_valid = (op <= 3'd4);
    assign accept   = (st_q == ST_IDLE) && start && op_valid;
    assign cfg_new  = (cfg_q & ~ECC_MASK) | (want_q ? ECC_MASK : 8'h00);

    snand_addr_pack #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .row           (row_q),
        .col           (col_q),
        .row_addr      (row_addr),
        .cache_rd_addr (cache_rd_addr),
        .cache_ld_addr (cache_ld_addr)
    );

    snand_stat_eval u_eval (
        .op       (op_q),
        .stat     (fr_rdata),
        .dev_busy (dev_busy),
        .rc       (eval_rc),
        .read_go  (read_go)
    );

    snand_cycle_timer #(.W(TMO_W)) u_poll_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_POLL),
        .limit   (tmo_q),
        .expired (tmo_exp)
    );

    snand_cycle_timer #(.W(RW_W)) u_rst_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_RST_WAIT),
        .limit   (RW_W'(RST_WAIT)),
        .expired (wait_exp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_e'(op))
                        OP_READ:   st_d = ST_PAGE_LD;
                        OP_PROG:   st_d = ST_WREN;
                        OP_ERASE:  st_d = ST_WREN;
                        OP_RESET:  st_d = ST_RST_CMD;
                        OP_ECCCFG: st_d = ST_CFG_RD;
                        default:   st_d = ST_IDLE;
                    endcase
                end
            end
            ST_WREN:     if (fr_done) st_d = (op_q == OP_PROG) ? ST_CACHE_LD : ST_ERASE;
            ST_CACHE_LD: if (fr_done) st_d = ST_EXEC;
            ST_EXEC:     if (fr_done) st_d = ST_POLL;
            ST_ERASE:    if (fr_done) st_d = ST_POLL;
            ST_PAGE_LD:  if (fr_done) st_d = ST_POLL;
            ST_POLL: begin
                if (fr_done) begin
                    if (dev_busy)                        st_d = tmo_exp ? ST_DONE : ST_POLL;
                    else if (op_q == OP_READ && read_go) st_d = ST_CACHE_RD;
                    else                                 st_d = ST_DONE;
                end
            end
            ST_CACHE_RD: if (fr_done) st_d = ST_DONE;
            ST_RST_CMD:  if (fr_done) st_d = ST_RST_WAIT;
            ST_RST_WAIT: if (wait_exp) st_d = ST_POLL;
            ST_CFG_RD: begin
                if (fr_done) st_d = (fr_rdata[CFG_ECC_BIT] == want_q) ? ST_DONE : ST_CFG_WR;
            end
            ST_CFG_WR:   if (fr_done) st_d = ST_DONE;
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // operation context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            rc_q   <= RC_OK;
            row_q  <= '0;
            col_q  <= '0;
            len_q  <= '0;
            tmo_q  <= '0;
            want_q <= 1'b0;
            cfg_q  <= 8'h00;
        end else begin
            if (accept) begin
                op_q   <= op_e'(op);
                rc_q   <= RC_OK;
                row_q  <= row;
                col_q  <= col;
                len_q  <= len;
                tmo_q  <= tmo_limit;
                want_q <= ecc_on;
            end
            if (st_q == ST_POLL && fr_done) begin
                if (dev_busy) begin
                    if (tmo_exp) rc_q <= RC_TIMEOUT;
                end else begin
                    rc_q <= eval_rc;
                end
            end
            if (st_q == ST_CFG_RD && fr_done) cfg_q <= fr_rdata;
        end
    end

    // outputs
    always_comb begin
        fr_req    = 1'b0;
        fr_opcode = 8'h00;
        fr_naddr  = 2'd0;
        fr_addr   = 24'h0;
        fr_dir    = DIR_NONE;
        fr_local  = 1'b0;
        fr_len    = '0;
        fr_wbyte  = 8'h00;
        unique case (st_q)
            ST_WREN: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_WREN;
            end
            ST_PAGE_LD: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_PAGE_LOAD;
                fr_naddr  = 2'd3;
                fr_addr   = row_addr;
            end
            ST_CACHE_LD: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_CACHE_LD;
                fr_naddr  = 2'd2;
                fr_addr   = cache_ld_addr;
                fr_dir    = DIR_TX;
                fr_len    = len_q;
            end
            ST_EXEC: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_EXEC;
                fr_naddr  = 2'd3;
                fr_addr   = row_addr;
            end
            ST_ERASE: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_BLK_ERASE;
                fr_naddr  = 2'd3;
                fr_addr   = row_addr;
            end
            ST_POLL: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_GET_REG;
                fr_naddr  = 2'd1;
                fr_addr   = {16'h0000, STAT_REG};
                fr_dir    = DIR_RX;
                fr_local  = 1'b1;
                fr_len    = ONE_BYTE;
            end
            ST_CACHE_RD: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_CACHE_RD;
                fr_naddr  = 2'd3;
                fr_addr   = cache_rd_addr;
                fr_dir    = DIR_RX;
                fr_len    = len_q;
            end
            ST_RST_CMD: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_RESET;
            end
            ST_CFG_RD: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_GET_REG;
                fr_naddr  = 2'd1;
                fr_addr   = {16'h0000, CFG_REG};
                fr_dir    = DIR_RX;
                fr_local  = 1'b1;
                fr_len    = ONE_BYTE;
            end
            ST_CFG_WR: begin
                fr_req    = 1'b1;
                fr_opcode = OPC_SET_REG;
                fr_naddr  = 2'd1;
                fr_addr   = {16'h0000, CFG_REG};
                fr_dir    = DIR_TX;
                fr_local  = 1'b1;
                fr_len    = ONE_BYTE;
                fr_wbyte  = cfg_new;
            end
            default: ;
        endcase
    end

    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_DONE);
    assign code = rc_q;

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_req && !fr_done) |=> (fr_req && $stable(fr_opcode) && $stable(fr_addr) && $stable(fr_len))); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fr_req); // R12

    AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && code == RC_TIMEOUT) |-> $past(tmo_exp)); // R9

    AST_NO_BAD_CACHE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_req && fr_opcode == OPC_CACHE_RD) |-> (code != RC_ECC_BAD)); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> $stable(op_q)); // R1
endmodule

// File: tb/snand_seq_tb.sv
module snand_seq_tb;
    localparam int ROW_W = 17, COL_W = 12, LEN_W = 12, TMO_W = 16;
    localparam int RST_WAIT = 20, LAT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [ROW_W-1:0] row = '0;
    logic [COL_W-1:0] col = '0;
    logic [LEN_W-1:0] len = '0;
    logic ecc_on = 1'b0;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic busy, done;
    logic [2:0] code;
    logic fr_req, fr_local;
    logic [7:0] fr_opcode, fr_wbyte;
    logic [1:0] fr_naddr, fr_dir;
    logic [23:0] fr_addr;
    logic [LEN_W-1:0] fr_len;
    logic fr_done = 1'b0;
    logic [7:0] fr_rdata = 8'h00;

    always #4 clk = ~clk;

    snand_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .TMO_W(TMO_W),
                .RST_WAIT(RST_WAIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .row(row), .col(col),
        .len(len), .ecc_on(ecc_on), .tmo_limit(tmo_limit), .busy(busy), .done(done),
        .code(code), .fr_req(fr_req), .fr_opcode(fr_opcode), .fr_naddr(fr_naddr),
        .fr_addr(fr_addr), .fr_dir(fr_dir), .fr_local(fr_local), .fr_len(fr_len),
        .fr_wbyte(fr_wbyte), .fr_done(fr_done), .fr_rdata(fr_rdata));

    int nchk = 0, nfail = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // frame engine and device model
    logic [56:0] log_f [0:63];
    int          log_t [0:63];
    int n_log = 0, lat_cnt = 0, busy_left = 0;
    bit pend = 0;
    logic [7:0] stat_final = 8'h00, cfg_model = 8'h00;

    function automatic logic [56:0] mkf(logic [7:0] o, logic [1:0] na, logic [23:0] a,
                                        logic [1:0] d, logic l, logic [11:0] n, logic [7:0] w);
        return {o, na, a, d, l, n, w};
    endfunction

    always @(negedge clk) begin
        if (fr_done) begin
            fr_done = 1'b0;
            pend = 0;
        end else if (fr_req && !pend) begin
            pend = 1;
            lat_cnt = LAT;
        end else if (pend) begin
            if (lat_cnt > 0) lat_cnt--;
            if (lat_cnt == 0) begin
                fr_rdata = 8'h00;
                if (fr_opcode == 8'h0F && fr_addr[7:0] == 8'hC0) begin
                    if (busy_left > 0) begin busy_left--; fr_rdata = 8'h01; end
                    else fr_rdata = stat_final;
                end else if (fr_opcode == 8'h0F && fr_addr[7:0] == 8'hB0) begin
                    fr_rdata = cfg_model;
                end else if (fr_opcode == 8'h1F) begin
                    cfg_model = fr_wbyte;
                end
                if (n_log < 64) begin
                    log_f[n_log] = mkf(fr_opcode, fr_naddr, fr_addr, fr_dir, fr_local, fr_len, fr_wbyte);
                    log_t[n_log] = cyc;
                    n_log++;
                end
                fr_done = 1'b1;
            end
        end
    end

    // expected frames
    logic [56:0] ex [0:63];
    int n_ex = 0;
    logic [2:0] got_code;

    task automatic push(logic [56:0] f);
        ex[n_ex] = f;
        n_ex++;
    endtask

    function automatic logic [56:0] f_poll();
        return mkf(8'h0F, 2'd1, 24'h0000C0, 2'd2, 1'b1, 12'd1, 8'h00);
    endfunction

    function automatic logic [56:0] f_row(logic [7:0] o, logic [ROW_W-1:0] r);
        return mkf(o, 2'd3, 24'(r), 2'd0, 1'b0, 12'd0, 8'h00);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_frames(string req);
        int bad = -1;
        for (int i = 0; i < n_ex; i++)
            if (bad < 0 && (i >= n_log || log_f[i] !== ex[i])) bad = i;
        if (n_log != n_ex && bad < 0) bad = n_ex;
        if (bad >= 0 && bad < n_ex && bad < n_log)
            chk(0, req, $sformatf("frame %0d", bad), longint'(log_f[bad]), longint'(ex[bad]));
        else
            chk(bad < 0, req, "frame count", n_log, n_ex);
    endtask

    task automatic run_op(logic [2:0] o, logic [ROW_W-1:0] r, logic [COL_W-1:0] c,
                          logic [LEN_W-1:0] n, logic e, logic [TMO_W-1:0] t,
                          int nbusy, logic [7:0] fin);
        bit seen = 0;
        busy_left = nbusy;
        stat_final = fin;
        n_log = 0;
        n_ex = 0;
        @(negedge clk);
        op = o; row = r; col = c; len = n; ecc_on = e; tmo_limit = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        for (int k = 0; k < 4000; k++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, "R12", "done seen", seen, 1);
        got_code = code;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R12", "idle after done", {busy, done}, 0);
    endtask

    function automatic logic [7:0] hib(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
        return {3'b000, r[6], c[11:8]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R12 watchdog: actual hung expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [ROW_W-1:0] rows [0:3];
        logic [COL_W-1:0] cols [0:3];
        rows[0] = 17'h00040; rows[1] = 17'h1ABCD; rows[2] = 17'h00003; rows[3] = 17'h1FFBF;
        cols[0] = 12'h000;   cols[1] = 12'h83F;   cols[2] = 12'hF01;   cols[3] = 12'h7FF;

        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fr_req == 0, "R12", "reset state", {busy, done, fr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R7 / R8: read sweep, fail bits 3 and 2 always set
        for (int i = 0; i < 4; i++) begin
            for (int e = 0; e < 4; e++) begin
                logic [2:0] xc;
                run_op(3'd0, rows[i], cols[i], 12'd2112 - 12'(i), 1'b0, 16'hFFFF, (i + e) % 3,
                       {2'b00, 2'(e), 4'b1100});
                xc = (e == 0) ? 3'd0 : (e == 1) ? 3'd1 : 3'd2;
                push(f_row(8'h13, rows[i]));
                for (int p = 0; p <= (i + e) % 3; p++) push(f_poll());
                if (e < 2) push(mkf(8'h03, 2'd3, {hib(rows[i], cols[i]), cols[i][7:0], 8'hFF},
                                    2'd2, 1'b0, 12'd2112 - 12'(i), 8'h00));
                chk(got_code == xc, "R7", "read code", got_code, xc);
                cmp_frames("R3");
            end
        end

        // R4 / R8: program sweep
        for (int i = 0; i < 4; i++) begin
            for (int f = 0; f < 2; f++) begin
                run_op(3'd1, rows[i], cols[i], 12'd64 + 12'(i), 1'b0, 16'hFFFF, i % 3,
                       f ? 8'h08 : 8'h34);
                push(mkf(8'h06, 0, 0, 0, 0, 0, 0));
                push(mkf(8'h84, 2'd2, {8'h00, hib(rows[i], cols[i]), cols[i][7:0]},
                         2'd1, 1'b0, 12'd64 + 12'(i), 8'h00));
                push(f_row(8'h10, rows[i]));
                for (int p = 0; p <= i % 3; p++) push(f_poll());
                chk(got_code == (f ? 3'd3 : 3'd0), "R8", "program code", got_code, f ? 3 : 0);
                cmp_frames("R4");
            end
        end

        // R5 / R8: erase sweep
        for (int i = 0; i < 4; i++) begin
            for (int f = 0; f < 2; f++) begin
                run_op(3'd2, rows[i], cols[i], 12'd0, 1'b0, 16'hFFFF, (i + 1) % 3,
                       f ? 8'h04 : 8'h38);
                push(mkf(8'h06, 0, 0, 0, 0, 0, 0));
                push(f_row(8'hD8, rows[i]));
                for (int p = 0; p <= (i + 1) % 3; p++) push(f_poll());
                chk(got_code == (f ? 3'd4 : 3'd0), "R8", "erase code", got_code, f ? 4 : 0);
                cmp_frames("R5");
            end
        end

        // R6 / R9: timeout boundaries
        run_op(3'd2, 17'h00100, 12'd0, 12'd0, 1'b0, 16'd30, 100000, 8'h00);
        chk(got_code == 3'd5, "R9", "never ready", got_code, 5);
        run_op(3'd2, 17'h00100, 12'd0, 12'd0, 1'b0, 16'd0, 1, 8'h00);
        chk(got_code == 3'd5, "R9", "zero limit", got_code, 5);
        chk(n_log == 3, "R9", "frames before zero-limit timeout", n_log, 3);
        run_op(3'd0, 17'h00100, 12'd0, 12'd4, 1'b0, 16'd30, 3, 8'h00);
        chk(got_code == 3'd0, "R6", "ready before limit", got_code, 0);
        chk(n_log == 6, "R6", "poll repeated while busy", n_log, 6);

        // R10: reset
        for (int b = 0; b < 3; b++) begin
            run_op(3'd3, 17'h0, 12'd0, 12'd0, 1'b0, 16'hFFFF, b, 8'h00);
            push(mkf(8'hFF, 0, 0, 0, 0, 0, 0));
            for (int p = 0; p <= b; p++) push(f_poll());
            chk(got_code == 3'd0, "R10", "reset code", got_code, 0);
            cmp_frames("R10");
            chk(log_t[1] - log_t[0] >= RST_WAIT, "R10", "quiet gap", log_t[1] - log_t[0], RST_WAIT);
        end

        // R11: ECC switch
        cfg_model = 8'h2A;
        run_op(3'd4, 17'h0, 12'd0, 12'd0, 1'b1, 16'hFFFF, 0, 8'h00);
        push(mkf(8'h0F, 2'd1, 24'h0000B0, 2'd2, 1'b1, 12'd1, 8'h00));
        push(mkf(8'h1F, 2'd1, 24'h0000B0, 2'd1, 1'b1, 12'd1, 8'h3A));
        cmp_frames("R11");
        chk(got_code == 3'd0, "R11", "switch on code", got_code, 0);
        run_op(3'd4, 17'h0, 12'd0, 12'd0, 1'b1, 16'hFFFF, 0, 8'h00);
        push(mkf(8'h0F, 2'd1, 24'h0000B0, 2'd2, 1'b1, 12'd1, 8'h00));
        cmp_frames("R11");
        chk(cfg_model == 8'h3A, "R11", "no write when equal", cfg_model, 8'h3A);
        cfg_model = 8'hFF;
        run_op(3'd4, 17'h0, 12'd0, 12'd0, 1'b0, 16'hFFFF, 0, 8'h00);
        chk(cfg_model == 8'hEF, "R11", "switch off keeps other bits", cfg_model, 8'hEF);

        // R1: invalid opcodes ignored
        for (int o = 5; o < 8; o++) begin
            bit rose = 0;
            n_log = 0;
            @(negedge clk);
            op = 3'(o); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (busy) rose = 1;
                @(negedge clk);
            end
            chk(!rose && n_log == 0, "R1", $sformatf("op %0d ignored", o), {rose, 8'(n_log)}, 0);
        end

        // R1: start during a running read is ignored
        fork
            run_op(3'd0, 17'h00041, 12'h123, 12'd8, 1'b0, 16'hFFFF, 3, 8'h00);
            begin
                repeat (6) @(negedge clk);
                op = 3'd2; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        push(f_row(8'h13, 17'h00041));
        for (int p = 0; p < 4; p++) push(f_poll());
        push(mkf(8'h03, 2'd3, {8'h11, 8'h23, 8'hFF}, 2'd2, 1'b0, 12'd8, 8'h00));
        cmp_frames("R1");
        begin
            bit rose = 0;
            for (int k = 0; k < 10; k++) begin
                if (busy) rose = 1;
                @(negedge clk);
            end
            chk(!rose, "R1", "no queued operation", rose, 0);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule